// File: doc/BRIEF.md
# Numerically Controlled Oscillator Core with Word-Decoded Control

This block takes 16-bit configuration words, one per clock when a write strobe is high, and uses them to drive a 28-bit phase accumulator. The two top bits of each word pick its target. One target is a 14-bit configuration register. The others are two 28-bit tuning words, which are loaded in 14-bit halves, and two 12-bit phase offsets. On every clock the accumulator advances by the tuning word that the configuration selects.

The top 12 bits of the accumulator are added to the selected phase offset. That sum is the output phase. From the phase the block forms a 10-bit waveform code and a one-bit square output, and both are registered together with the phase. The waveform code is either the plain phase (a stand-in for a sine lookup that lives elsewhere) or a triangle. The square output is either the phase MSB or that MSB divided by two. Configuration bits can hold the accumulator at zero, freeze it, or blank the waveform code.

Top module: `dds_core`

## Requirements
- R1: When `wrEn` is high and `wrWord[15:14]` is 00, the configuration register takes this layout: bit 13 pairs writes (pair mode), bit 12 picks the half, bit 11 picks the tuning word, bit 10 picks the phase offset, bit 8 clears the accumulator, bit 7 freezes it, bit 6 blanks the waveform code, bit 5 enables the square output, bit 3 picks the divider, bit 1 picks triangle. Bits 9, 4, 2 and 0 have no effect. A configuration write also restarts the write pairing.
- R2: `wrWord[15:14]` = 01 writes tuning word 0, and 10 writes tuning word 1. In pair mode the writes alternate between the two halves, lower half (bits 13:0) first and upper half (bits 27:14) second. One shared pairing state covers both tuning words.
- R3: When pair mode is off, a tuning write loads `wrWord[13:0]` into the upper half if bit 12 is 1 and into the lower half if bit 12 is 0. The other half keeps its value.
- R4: `wrWord[15:14]` = 11 loads `wrWord[11:0]` into phase offset `wrWord[13]`.
- R5: On each clock, with the clear and freeze bits both 0, the accumulator grows by the selected tuning word, modulo 2^28.
- R6: After each clock edge, `phaseOut` equals the accumulator's top 12 bits plus the selected phase offset, modulo 4096, both taken as they were before that edge. A tuning write therefore first shows at `phaseOut` two edges after the edge that captures it.
- R7: While the clear bit is 1, the accumulator is held at zero. The tuning words and phase offsets keep their values, and writes to them still take effect.
- R8: While the freeze bit is 1 and the clear bit is 0, the accumulator keeps its value.
- R9: When the blank bit or the square-enable bit is 1, `dacOut` is 0.
- R10: Otherwise, with phase p, `dacOut` is p[11:2] when the triangle bit is 0. When the triangle bit is 1 it is p[10:1] if p[11] is 0, and the bitwise inverse of p[10:1] if p[11] is 1.
- R11: With square enable set, `sqOut` is p[11] when the divider bit is 1. When the divider bit is 0, `sqOut` is a toggle that flips on each rising edge of p[11]. With square enable clear, `sqOut` is 0.
- R12: While `rstN` is low, all registers and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Word write strobe |
| wrWord | input | 16 | Configuration / tuning / phase word |
| phaseOut | output | 12 | Registered output phase |
| dacOut | output | 10 | Registered waveform code |
| sqOut | output | 1 | Registered square output |

## Verification
The assertions assume that `wrEn` and `wrWord` are stable around the rising edge. They also assume that properties stated over one edge start only from cycles in which `rstN` is already high. The stimulus therefore changes inputs only on the falling edge and releases reset on a falling edge. Reserved configuration bits are sometimes written as 1 on purpose, to show that they have no effect. The other words stay within the four defined target codes.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int WORD_W = 16;
  localparam int ACC_W  = 28;
  localparam int HALF_W = ACC_W / 2;
  localparam int PH_W   = 12;
  localparam int DAC_W  = 10;
  localparam int NCH    = 2;

  typedef struct packed {
    logic pairMode;
    logic upperSel;
    logic freqSel;
    logic phaseSel;
    logic accClear;
    logic accFreeze;
    logic dacBlank;
    logic sqEnable;
    logic sqDirect;
    logic triMode;
  } cfg_t;

  typedef struct packed {
    logic [NCH-1:0]    ldLo;
    logic [NCH-1:0]    ldHi;
    logic [NCH-1:0]    ldPh;
    logic [HALF_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrWord,
  output cfg_t              cfg,
  output strobe_t           stb
);
  logic [1:0] target;
  logic       upperNext;
  logic       isFreq;

  assign target = wrWord[WORD_W-1 -: 2];
  assign isFreq = (target == 2'b01) || (target == 2'b10);

  always_comb begin
    stb      = '0;
    stb.data = wrWord[HALF_W-1:0];
    if (wrEn) begin
      if (isFreq) begin
        if (cfg.pairMode) begin
          if (upperNext) stb.ldHi[target[1]] = 1'b1;
          else           stb.ldLo[target[1]] = 1'b1;
        end else if (cfg.upperSel) begin
          stb.ldHi[target[1]] = 1'b1;
        end else begin
          stb.ldLo[target[1]] = 1'b1;
        end
      end else if (target == 2'b11) begin
        stb.ldPh[wrWord[HALF_W-1]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= '0;
      upperNext <= 1'b0;
    end else if (wrEn) begin
      if (target == 2'b00) begin
        cfg.pairMode  <= wrWord[13];
        cfg.upperSel  <= wrWord[12];
        cfg.freqSel   <= wrWord[11];
        cfg.phaseSel  <= wrWord[10];
        cfg.accClear  <= wrWord[8];
        cfg.accFreeze <= wrWord[7];
        cfg.dacBlank  <= wrWord[6];
        cfg.sqEnable  <= wrWord[5];
        cfg.sqDirect  <= wrWord[3];
        cfg.triMode   <= wrWord[1];
        upperNext     <= 1'b0;
      end else if (isFreq && cfg.pairMode) begin
        upperNext <= ~upperNext;
      end
    end
  end

  // R1: a configuration write lands in the register on the next edge
  p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrWord[15:14] == 2'b00) |=>
      (cfg.triMode == $past(wrWord[1]) && cfg.freqSel == $past(wrWord[11])));

  // R2: at most one tuning-word half is loaded per write
  p_one_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldLo, stb.ldHi}));
endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  strobe_t          stb,
  output logic [PH_W-1:0]  phaseOut,
  output logic [DAC_W-1:0] dacOut,
  output logic             sqOut
);
  logic [ACC_W-1:0] freqReg  [NCH];
  logic [PH_W-1:0]  phaseReg [NCH];
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] freqCur;
  logic [PH_W-1:0]  phaseSum;
  logic [DAC_W-1:0] triCode, stubCode, dacNext;
  logic             prevMsb, halfSq, halfNext, msbRise;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        freqReg[g]  <= '0;
        phaseReg[g] <= '0;
      end else begin
        if (stb.ldLo[g]) freqReg[g][HALF_W-1:0]     <= stb.data;
        if (stb.ldHi[g]) freqReg[g][ACC_W-1:HALF_W] <= stb.data;
        if (stb.ldPh[g]) phaseReg[g]                <= stb.data[PH_W-1:0];
      end
    end
  end

  assign freqCur = freqReg[cfg.freqSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               acc <= '0;
    else if (cfg.accClear)   acc <= '0;
    else if (!cfg.accFreeze) acc <= acc + freqCur;
  end

  assign phaseSum = acc[ACC_W-1 -: PH_W] + phaseReg[cfg.phaseSel];
  assign stubCode = phaseSum[PH_W-1 -: DAC_W];
  assign triCode  = phaseSum[PH_W-1] ? ~phaseSum[PH_W-2 -: DAC_W]
                                     :  phaseSum[PH_W-2 -: DAC_W];

  always_comb begin
    if (cfg.dacBlank || cfg.sqEnable) dacNext = '0;
    else if (cfg.triMode)             dacNext = triCode;
    else                              dacNext = stubCode;
  end

  assign msbRise  = phaseSum[PH_W-1] & ~prevMsb;
  assign halfNext = halfSq ^ msbRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseOut <= '0;
      dacOut   <= '0;
      sqOut    <= 1'b0;
      prevMsb  <= 1'b0;
      halfSq   <= 1'b0;
    end else begin
      phaseOut <= phaseSum;
      dacOut   <= dacNext;
      prevMsb  <= phaseSum[PH_W-1];
      halfSq   <= halfNext;
      sqOut    <= cfg.sqEnable ? (cfg.sqDirect ? phaseSum[PH_W-1] : halfNext) : 1'b0;
    end
  end

  p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfg.accClear |=> (acc == '0));

  p_acc_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.accFreeze && !cfg.accClear) |=> $stable(acc));

  p_acc_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.accFreeze && !cfg.accClear) |=> (acc == ACC_W'($past(acc) + $past(freqCur))));

  p_dac_blank_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.dacBlank || cfg.sqEnable) |=> (dacOut == '0));

  p_sq_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.sqEnable |=> !sqOut);
endmodule

// File: rtl/dds_core.sv
module dds_core
  import dds_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrWord,
  output logic [PH_W-1:0]   phaseOut,
  output logic [DAC_W-1:0]  dacOut,
  output logic              sqOut
);
  cfg_t    cfg;
  strobe_t stb;

  dds_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWord(wrWord),
    .cfg(cfg), .stb(stb)
  );

  dds_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb),
    .phaseOut(phaseOut), .dacOut(dacOut), .sqOut(sqOut)
  );
endmodule

// File: tb/tb_dds_core.sv
module tb_dds_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrWord = '0;
  logic [11:0] phaseOut;
  logic [9:0]  dacOut;
  logic        sqOut;

  dds_core dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWord(wrWord),
                .phaseOut(phaseOut), .dacOut(dacOut), .sqOut(sqOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [11:0] ph;
    logic [9:0]  dac;
    logic        sq;
    string       req;
  } exp_t;

  exp_t  q[$];
  int    nChk = 0, nBad = 0;
  string curReq = "R12";
  bit    done = 1'b0;

  logic [27:0] mAcc;
  logic [27:0] mF [2];
  logic [11:0] mP [2];
  logic [13:0] mCtrl;
  logic        mUp, mPrev, mHalf;

  task automatic modelReset();
    mAcc = '0; mF[0] = '0; mF[1] = '0; mP[0] = '0; mP[1] = '0;
    mCtrl = '0; mUp = 0; mPrev = 0; mHalf = 0;
  endtask

  task automatic predict(input bit en, input logic [15:0] w);
    exp_t e;
    logic [11:0] p;
    logic hn;
    logic k;
    p = mAcc[27:16] + mP[mCtrl[10]];
    if (mCtrl[6] || mCtrl[5]) e.dac = '0;
    else if (mCtrl[1])        e.dac = p[11] ? ~p[10:1] : p[10:1];
    else                      e.dac = p[11:2];
    hn = mHalf ^ (p[11] & ~mPrev);
    e.sq  = mCtrl[5] ? (mCtrl[3] ? p[11] : hn) : 1'b0;
    e.ph  = p;
    e.req = curReq;
    q.push_back(e);
    mPrev = p[11];
    mHalf = hn;
    if (mCtrl[8])       mAcc = '0;
    else if (!mCtrl[7]) mAcc = mAcc + mF[mCtrl[11]];
    if (en) begin
      case (w[15:14])
        2'b00: begin mCtrl = w[13:0] & 14'h3DEA; mUp = 0; end
        2'b11: mP[w[13]] = w[11:0];
        default: begin
          k = w[15];
          if (mCtrl[13]) begin
            if (mUp) mF[k][27:14] = w[13:0];
            else     mF[k][13:0]  = w[13:0];
            mUp = ~mUp;
          end else if (mCtrl[12]) mF[k][27:14] = w[13:0];
          else                    mF[k][13:0]  = w[13:0];
        end
      endcase
    end
  endtask

  task automatic drive(input bit en, input logic [15:0] w);
    @(negedge clk);
    wrEn = en;
    wrWord = w;
    predict(en, w);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 16'h0000);
  endtask

  always @(posedge clk) begin
    #2;
    if (rstN && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      nChk++;
      if (phaseOut !== e.ph || dacOut !== e.dac || sqOut !== e.sq) begin
        nBad++;
        $display("FAIL %s: got ph=%h dac=%h sq=%b, expected ph=%h dac=%h sq=%b",
                 e.req, phaseOut, dacOut, sqOut, e.ph, e.dac, e.sq);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    nChk++;
    if (phaseOut !== '0 || dacOut !== '0 || sqOut !== 1'b0) begin
      nBad++;
      $display("FAIL R12: got ph=%h dac=%h sq=%b, expected all zero", phaseOut, dacOut, sqOut);
    end
    rstN = 1'b1;

    curReq = "R1";  drive(1, 16'h2215);
    curReq = "R2";  drive(1, 16'h4123); drive(1, 16'h4100); idle(70);
    curReq = "R3";  drive(1, 16'h0000); drive(1, 16'h8555);
                    drive(1, 16'h1000); drive(1, 16'h80C0);
                    drive(1, 16'h1800); idle(40);
    curReq = "R4";  drive(1, 16'hE800); drive(1, 16'hC321);
                    drive(1, 16'h0400); idle(10); drive(1, 16'h0000); idle(5);
    curReq = "R6";  drive(1, 16'h2000); drive(1, 16'h4000); drive(1, 16'h4200); idle(8);
    curReq = "R10"; drive(1, 16'h0002); idle(80);
    curReq = "R9";  drive(1, 16'h0040); idle(10);
    curReq = "R11"; drive(1, 16'h0020); idle(140); drive(1, 16'h0028); idle(80);
    curReq = "R8";  drive(1, 16'h0080); idle(10);
    curReq = "R7";  drive(1, 16'h0100); idle(5);
                    drive(1, 16'h4010); idle(5);
                    drive(1, 16'h0000); idle(20);
    curReq = "R5";  drive(1, 16'h2800); drive(1, 16'h8FFF); drive(1, 16'h BFFF); idle(20);
    curReq = "R1";  drive(1, 16'h0215); idle(20);

    drive(0, 16'h0000);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule